// File: doc/BRIEF.md
# Fixed-Point Exception Flag Updater

This block decides, for each retiring fixed-point operation, which of the five fixed-point exception flags the operation writes and what each written flag becomes. The five flags are the sticky summary overflow, overflow, carry, and the 32-bit views of overflow and carry. The execution units supply raw boundary information: carries out of the 32-bit and 64-bit result fields, the carries into their sign positions, "result fits" indications from the multiplier or divider, and the sign and lost-bit indications from the algebraic right shift. The block applies the flag rules of the operation class to these inputs. It does no datapath arithmetic.

The results leave through a single registered stage that loads when `in_valid` is high. The stage presents one write enable per flag, so a dependency scoreboard can track every flag as its own register. The same result is also given with each flag placed at its bit position in the 64-bit exception register, as a value and a matching write mask. A flag whose enable is low must keep its old value in the register file.

Top module: `xer_flag_updater`

## Requirements
- R1: `flag_new`/`flag_we` bit order is 0=SO, 1=OV, 2=CA, 3=OV32, 4=CA32. `xer_val`/`xer_mask` carry the same flags at register bits 32 (SO), 33 (OV), 34 (CA), 44 (OV32) and 45 (CA32). All other bits of both vectors are 0.
- R2: Class 0 (add, subtract-from, negate) with `oe`=1 writes OV, OV32 and SO. OV is `carry_hi`^`carry_sgn` at the boundary selected by `mode64` (1 selects 64-bit). OV32 uses the 32-bit pair. With `oe`=0, class 0 writes nothing.
- R3: Class 2 (extended add) with `cy_field`=0 writes OV from `carry_hi` at the selected boundary, OV32 from `carry_hi32`, and SO. It does not write CA. With `cy_field`≠0 it writes CA and CA32 from the same carries and does not write OV or SO.
- R4: Class 3 (multiply) and class 4 (divide) with `oe`=1 write OV=!`fits_m`, OV32=!`fits_32` and SO. With `oe`=0 they write nothing.
- R5: Class 1 (carrying add, subtract or extended subtract) always writes CA from `carry_hi` at the selected boundary and CA32 from `carry_hi32`. With `oe`=1 it also writes OV, OV32 and SO as in R2.
- R6: Class 5 (shift right algebraic) writes CA and CA32, both equal to `sra_neg`&`sra_lost`. It writes nothing else.
- R7: Class 6 (compare), class 8 (other) and the unused codes 9 to 15 raise no write enable.
- R8: Class 7 (move to special register) enables all five flags. Each flag takes `spr_src` at its register bit position from R1.
- R9: SO is sticky. Whenever OV is written outside class 7, SO is written as `so_in`|OV, so such a write never clears SO.
- R10: Results appear on the outputs one clock after a cycle with `in_valid`=1. After a cycle with `in_valid`=0, `out_valid` and every write enable are 0. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An operation's flag inputs are present this cycle |
| op_class | input | 4 | Operation class code (see R2 to R8) |
| oe | input | 1 | Overflow-enable bit of the instruction |
| cy_field | input | 2 | Extended-add carry-select field |
| mode64 | input | 1 | 1: 64-bit mode boundary, 0: 32-bit |
| so_in | input | 1 | Current summary overflow value |
| carry_hi32 | input | 1 | Carry out of the low 32-bit field |
| carry_sgn32 | input | 1 | Carry into bit 31 (sign of the 32-bit field) |
| carry_hi64 | input | 1 | Carry out of the 64-bit field |
| carry_sgn64 | input | 1 | Carry into bit 63 |
| fits_m | input | 1 | Multiply/divide result fits the mode-width target |
| fits_32 | input | 1 | Multiply/divide result fits 32 bits |
| sra_neg | input | 1 | Shift operand is negative |
| sra_lost | input | 1 | At least one 1-bit was shifted out |
| spr_src | input | 64 | Source value of a move to special register |
| out_valid | output | 1 | Registered results are valid |
| flag_new | output | 5 | New flag values (order in R1) |
| flag_we | output | 5 | Per-flag write enables |
| xer_val | output | 64 | Flag values at register bit positions |
| xer_mask | output | 64 | Write mask at register bit positions |

## Verification
Every result passes through exactly one register. Flags, enables, the placed value and the placed mask all belong to the operation driven in the previous cycle. The bench drives each operation on a falling edge and reads all outputs at the following falling edge, after the single rising edge between them, so every vector completes in one cycle. The sweep covers every class code, both modes, both `oe` values, zero and non-zero `cy_field`, and all 512 combinations of the nine single-bit flag inputs. Idle cycles between sweeps confirm that enables drop one cycle after `in_valid` falls.

// File: rtl/xfu_pkg.sv
package xfu_pkg;

    typedef enum logic [3:0] {
        OPC_ADDSUB = 4'd0,
        OPC_ADDC   = 4'd1,
        OPC_ADDEX  = 4'd2,
        OPC_MUL    = 4'd3,
        OPC_DIV    = 4'd4,
        OPC_SRA    = 4'd5,
        OPC_CMP    = 4'd6,
        OPC_MTSPR  = 4'd7,
        OPC_OTHER  = 4'd8
    } op_class_e;

    localparam int FLAG_N  = 5;
    localparam int FI_SO   = 0;
    localparam int FI_OV   = 1;
    localparam int FI_CA   = 2;
    localparam int FI_OV32 = 3;
    localparam int FI_CA32 = 4;

    // register bit positions, indexed by flag index
    function automatic int flag_pos(input int idx);
        case (idx)
            FI_SO:   return 32;
            FI_OV:   return 33;
            FI_CA:   return 34;
            FI_OV32: return 44;
            default: return 45;
        endcase
    endfunction

    typedef struct packed {
        logic ca32;
        logic ov32;
        logic ca;
        logic ov;
        logic so;
    } flag_vec_t;

endpackage

// File: rtl/xfu_ovf_unit.sv
module xfu_ovf_unit (
    input  logic sel_arith,
    input  logic sel_addex,
    input  logic sel_muldiv,
    input  logic mode64,
    input  logic carry_hi32,
    input  logic carry_sgn32,
    input  logic carry_hi64,
    input  logic carry_sgn64,
    input  logic fits_m,
    input  logic fits_32,
    output logic ov,
    output logic ov32,
    output logic ov_we
);
    logic dis_m, dis_32, hi_m;

    always_comb begin
        dis_32 = carry_hi32 ^ carry_sgn32;
        dis_m  = mode64 ? (carry_hi64 ^ carry_sgn64) : dis_32;
        hi_m   = mode64 ? carry_hi64 : carry_hi32;
        ov     = 1'b0;
        ov32   = 1'b0;
        ov_we  = 1'b0;
        if (sel_arith) begin
            ov    = dis_m;
            ov32  = dis_32;
            ov_we = 1'b1;
        end else if (sel_addex) begin
            ov    = hi_m;
            ov32  = carry_hi32;
            ov_we = 1'b1;
        end else if (sel_muldiv) begin
            ov    = ~fits_m;
            ov32  = ~fits_32;
            ov_we = 1'b1;
        end
    end
endmodule

// File: rtl/xfu_carry_unit.sv
module xfu_carry_unit (
    input  logic sel_carry,
    input  logic sel_sra,
    input  logic mode64,
    input  logic carry_hi32,
    input  logic carry_hi64,
    input  logic sra_neg,
    input  logic sra_lost,
    output logic ca,
    output logic ca32,
    output logic ca_we
);
    always_comb begin
        ca    = 1'b0;
        ca32  = 1'b0;
        ca_we = 1'b0;
        if (sel_carry) begin
            ca    = mode64 ? carry_hi64 : carry_hi32;
            ca32  = carry_hi32;
            ca_we = 1'b1;
        end else if (sel_sra) begin
            ca    = sra_neg & sra_lost;
            ca32  = sra_neg & sra_lost;
            ca_we = 1'b1;
        end
    end
endmodule

// File: rtl/xfu_bit_place.sv
module xfu_bit_place #(
    parameter int REG_W = 64
) (
    input  xfu_pkg::flag_vec_t flags,
    output logic [REG_W-1:0]   placed
);
    import xfu_pkg::*;
    logic [FLAG_N-1:0] fl;
    assign fl = flags;

    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int i = 0; i < FLAG_N; i++) begin
                if (flag_pos(i) == b) hit = fl[i];
            end
        end
        assign placed[b] = hit;
    end
endmodule

// File: rtl/xer_flag_updater.sv
module xer_flag_updater #(
    parameter int REG_W = 64,
    parameter int CY_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [3:0]       op_class,
    input  logic             oe,
    input  logic [CY_W-1:0]  cy_field,
    input  logic             mode64,
    input  logic             so_in,
    input  logic             carry_hi32,
    input  logic             carry_sgn32,
    input  logic             carry_hi64,
    input  logic             carry_sgn64,
    input  logic             fits_m,
    input  logic             fits_32,
    input  logic             sra_neg,
    input  logic             sra_lost,
    input  logic [REG_W-1:0] spr_src,
    output logic             out_valid,
    output logic [4:0]       flag_new,
    output logic [4:0]       flag_we,
    output logic [REG_W-1:0] xer_val,
    output logic [REG_W-1:0] xer_mask
);
    import xfu_pkg::*;

    op_class_e opc;
    logic sel_arith, sel_addex, sel_muldiv, sel_carry, sel_sra, sel_spr;
    logic ov, ov32, ov_we, ca, ca32, ca_we;
    flag_vec_t nxt_val, nxt_we, reg_val, reg_we;

    assign opc = op_class_e'(op_class);

    // class decode
    always_comb begin
        sel_arith  = 1'b0;
        sel_addex  = 1'b0;
        sel_muldiv = 1'b0;
        sel_carry  = 1'b0;
        sel_sra    = 1'b0;
        sel_spr    = 1'b0;
        unique case (opc)
            OPC_ADDSUB: sel_arith = oe;
            OPC_ADDC: begin
                sel_arith = oe;
                sel_carry = 1'b1;
            end
            OPC_ADDEX: begin
                sel_addex = (cy_field == '0);
                sel_carry = (cy_field != '0);
            end
            OPC_MUL, OPC_DIV: sel_muldiv = oe;
            OPC_SRA:   sel_sra = 1'b1;
            OPC_MTSPR: sel_spr = 1'b1;
            default: ;
        endcase
    end

    xfu_ovf_unit u_ovf (
        .sel_arith   (sel_arith),
        .sel_addex   (sel_addex),
        .sel_muldiv  (sel_muldiv),
        .mode64      (mode64),
        .carry_hi32  (carry_hi32),
        .carry_sgn32 (carry_sgn32),
        .carry_hi64  (carry_hi64),
        .carry_sgn64 (carry_sgn64),
        .fits_m      (fits_m),
        .fits_32     (fits_32),
        .ov          (ov),
        .ov32        (ov32),
        .ov_we       (ov_we)
    );

    xfu_carry_unit u_carry (
        .sel_carry  (sel_carry),
        .sel_sra    (sel_sra),
        .mode64     (mode64),
        .carry_hi32 (carry_hi32),
        .carry_hi64 (carry_hi64),
        .sra_neg    (sra_neg),
        .sra_lost   (sra_lost),
        .ca         (ca),
        .ca32       (ca32),
        .ca_we      (ca_we)
    );

    // merge: special-register move overrides, otherwise per-unit results
    always_comb begin
        if (sel_spr) begin
            nxt_val.so   = spr_src[flag_pos(FI_SO)];
            nxt_val.ov   = spr_src[flag_pos(FI_OV)];
            nxt_val.ca   = spr_src[flag_pos(FI_CA)];
            nxt_val.ov32 = spr_src[flag_pos(FI_OV32)];
            nxt_val.ca32 = spr_src[flag_pos(FI_CA32)];
            nxt_we       = '1;
        end else begin
            nxt_val.so   = ov_we & (so_in | ov);
            nxt_val.ov   = ov;
            nxt_val.ov32 = ov32;
            nxt_val.ca   = ca;
            nxt_val.ca32 = ca32;
            nxt_we.so    = ov_we;
            nxt_we.ov    = ov_we;
            nxt_we.ov32  = ov_we;
            nxt_we.ca    = ca_we;
            nxt_we.ca32  = ca_we;
        end
    end

    // output stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            reg_val   <= '0;
            reg_we    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                reg_val <= nxt_val;
                reg_we  <= nxt_we;
            end else begin
                reg_we  <= '0;
            end
        end
    end

    assign flag_new = reg_val;
    assign flag_we  = reg_we;

    xfu_bit_place #(.REG_W(REG_W)) u_place_val (
        .flags  (reg_val),
        .placed (xer_val)
    );

    xfu_bit_place #(.REG_W(REG_W)) u_place_mask (
        .flags  (reg_we),
        .placed (xer_mask)
    );
endmodule

// File: rtl/xfu_checker.sv
module xfu_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [3:0] op_class,
    input logic       oe,
    input logic       so_in,
    input logic       sra_neg,
    input logic       sra_lost,
    input logic       out_valid,
    input logic [4:0] flag_new,
    input logic [4:0] flag_we
);
    // R7: compare writes nothing
    assert_cmp_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_class == 4'd6) |=> (flag_we == 5'b0));

    // R2: add class without OE writes nothing
    assert_add_no_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_class == 4'd0 && !oe) |=> (flag_we == 5'b0));

    // R9: SO never written back to 0 when it was set, outside a register move
    assert_so_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_class != 4'd7 && so_in) |=> (!flag_we[0] || flag_new[0]));

    // R6: shift writes only the carry pair, with the negative-and-lost value
    assert_sra_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_class == 4'd5) |=>
            (flag_we == 5'b10100 && flag_new[2] == $past(sra_neg && sra_lost)));

    // R10: no enables without a valid result
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (flag_we == 5'b0));
endmodule

bind xer_flag_updater xfu_checker u_xfu_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_class  (op_class),
    .oe        (oe),
    .so_in     (so_in),
    .sra_neg   (sra_neg),
    .sra_lost  (sra_lost),
    .out_valid (out_valid),
    .flag_new  (flag_new),
    .flag_we   (flag_we)
);

// File: tb/tb_xer_flag_updater.sv
module tb_xer_flag_updater;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op_class = '0;
    logic        oe = 1'b0;
    logic [1:0]  cy_field = '0;
    logic        mode64 = 1'b0;
    logic        so_in = 1'b0;
    logic        carry_hi32 = 1'b0, carry_sgn32 = 1'b0;
    logic        carry_hi64 = 1'b0, carry_sgn64 = 1'b0;
    logic        fits_m = 1'b0, fits_32 = 1'b0;
    logic        sra_neg = 1'b0, sra_lost = 1'b0;
    logic [63:0] spr_src = '0;
    logic        out_valid;
    logic [4:0]  flag_new, flag_we;
    logic [63:0] xer_val, xer_mask;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    xer_flag_updater dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_class(op_class),
        .oe(oe), .cy_field(cy_field), .mode64(mode64), .so_in(so_in),
        .carry_hi32(carry_hi32), .carry_sgn32(carry_sgn32),
        .carry_hi64(carry_hi64), .carry_sgn64(carry_sgn64),
        .fits_m(fits_m), .fits_32(fits_32), .sra_neg(sra_neg), .sra_lost(sra_lost),
        .spr_src(spr_src), .out_valid(out_valid), .flag_new(flag_new),
        .flag_we(flag_we), .xer_val(xer_val), .xer_mask(xer_mask)
    );

    function automatic string req_of(input int opc);
        case (opc)
            0: return "R2";
            1: return "R5";
            2: return "R3";
            3, 4: return "R4";
            5: return "R6";
            7: return "R8";
            default: return "R7";
        endcase
    endfunction

    function automatic logic [63:0] place(input logic [4:0] f);
        logic [63:0] v = '0;
        v[32] = f[0]; v[33] = f[1]; v[34] = f[2]; v[44] = f[3]; v[45] = f[4];
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // expected flags from the requirements
    task automatic model(output logic [4:0] ev, output logic [4:0] ew);
        logic ovv, ov32v, ovw, cav, ca32v, caw;
        logic dm, d32, hm;
        d32 = carry_hi32 ^ carry_sgn32;
        dm  = mode64 ? (carry_hi64 ^ carry_sgn64) : d32;
        hm  = mode64 ? carry_hi64 : carry_hi32;
        ovv = 0; ov32v = 0; ovw = 0; cav = 0; ca32v = 0; caw = 0;
        case (op_class)
            4'd0: if (oe) begin ovv = dm; ov32v = d32; ovw = 1; end
            4'd1: begin
                cav = hm; ca32v = carry_hi32; caw = 1;
                if (oe) begin ovv = dm; ov32v = d32; ovw = 1; end
            end
            4'd2: if (cy_field == 0) begin ovv = hm; ov32v = carry_hi32; ovw = 1; end
                  else begin cav = hm; ca32v = carry_hi32; caw = 1; end
            4'd3, 4'd4: if (oe) begin ovv = !fits_m; ov32v = !fits_32; ovw = 1; end
            4'd5: begin cav = sra_neg & sra_lost; ca32v = cav; caw = 1; end
            default: ;
        endcase
        if (op_class == 4'd7) begin
            ev = {spr_src[45], spr_src[44], spr_src[34], spr_src[33], spr_src[32]};
            ew = 5'b11111;
        end else begin
            // R9: SO sticky on OV write
            ev = {ca32v, ov32v, cav, ovv, ovw & (so_in | ovv)};
            ew = {caw, ovw, caw, ovw, ovw};
        end
    endtask

    initial begin
        logic [4:0] ev, ew;
        string rq;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid == 0 && flag_we == 0 && xer_val == 0 && xer_mask == 0,
              "R10", "reset state", {out_valid, flag_we, xer_val[57:0]}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int opc = 0; opc < 16; opc++) begin
            for (int md = 0; md < 2; md++) begin
                for (int o = 0; o < 2; o++) begin
                    for (int cy = 0; cy < 2; cy++) begin
                        for (int pat = 0; pat < 512; pat++) begin
                            logic [8:0] p;
                            p = 9'(pat);
                            in_valid = 1'b1;
                            op_class = 4'(opc);
                            mode64 = md[0];
                            oe = o[0];
                            cy_field = cy[0] ? 2'd2 : 2'd0;
                            {so_in, carry_hi32, carry_sgn32, carry_hi64, carry_sgn64,
                             fits_m, fits_32, sra_neg, sra_lost} = p;
                            spr_src = {{7{p}}, p[0]} ^ 64'(pat * 37);
                            model(ev, ew);
                            rq = req_of(opc);
                            @(negedge clk);
                            check(out_valid == 1 && flag_we == ew, rq, "write enables",
                                  64'(flag_we), 64'(ew));
                            check(flag_new == ev || (ew == 0), rq, "flag values",
                                  64'(flag_new), 64'(ev));
                            // R1: register placement of values and mask
                            check(xer_mask == place(ew) && (ew == 0 || xer_val == place(ev)),
                                  "R1", "placed mask/value", xer_mask ^ xer_val,
                                  place(ew) ^ place(ev));
                        end
                    end
                end
            end
            // R10: one idle cycle drops enables
            in_valid = 1'b0;
            op_class = 4'd7;
            @(negedge clk);
            check(out_valid == 0 && flag_we == 0, "R10", "idle cycle",
                  {63'(flag_we), out_valid}, 64'h0);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R10 watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule